// File: doc/BRIEF.md
# Multiport Repeater Core Controller

This block is the central arbiter of a six-port shared-medium repeater: five local ports and one dedicated port, indexed 0 to 5. From the carrier-sense bits of the ports and the data-valid flag of the port that is receiving, it chooses one of five operating states: quiet, forwarding from a local port, forwarding from the cascade bus, jamming, and last-port jamming. In each state it drives the per-port receive and transmit enables, the enables towards the cascade bus and a jam-select flag for the datapath. The data FIFO, the MII nibble path and the content of the jam pattern are outside this block.

When several repeaters are stacked, they share an 8-line active-low activity bus. Each device pulls down the line whose index is its 3-bit repeater ID while one local port is active. During a local collision it also pulls down a second line, the one below its ID. Both the carrier bits and the bus lines are asynchronous and pass through two-flop synchronizers into the 25 MHz local clock domain. When the device reads the bus back, it ignores the lines it drove itself.

Top module: `rpt_core_ctrl`

## Requirements
- R1: While `rstN` is low and right after it is released, every receive and transmit enable, `irRxEn`, `irTxEn` and `jamSel` are 0, and `irActOutN` is all ones.
- R2: With exactly one carrier bit X high, no remote activity and `rxDv` high, the block forwards. In this state `rxEn` has only bit X set, `txEn` has every bit except X set, and `irRxEn` and `jamSel` are 0. No port ever has its receive and transmit enables set together.
- R3: While forwarding from either source, a port whose `jabber` or `partition` bit is 1 has its `txEn` bit at 0. A change of those inputs shows on `txEn` in the same cycle.
- R4: With two or more carrier bits high, the block jams: `rxEn` is 0, `txEn` is all ones (jabbered and partitioned ports included), `jamSel` is 1, and `irRxEn` and `irTxEn` are 0.
- R5: Suppose a collision involved two or more sources and then only one local carrier X remains, with no remote activity. The block then enters last-port jamming: `txEn` has every bit except X set, `rxEn` is 0 and `jamSel` is 1. When X drops as well, all outputs return to the quiet values.
- R6: A single carrier with `rxDv` low forwards for exactly 5 cycles and then jams. The jam continues for as long as that carrier stays high, and last-port jamming is not entered.
- R7: `irActOutN` is active low, and bit i is line i. With cascade enabled and one local carrier, only bit `repId` is 0. With two or more local carriers, bit `repId-1` is also 0, or bit 1 when `repId` is 0. With no carrier, or with cascade disabled, all bits are 1.
- R8: With cascade enabled, forwarding from a local port sets `irTxEn` to 1 and `irRxEn` to 0. The device's own activity lines, read back on `irActInN`, never count as remote activity.
- R9: With cascade enabled, no local carrier and exactly one foreign line of `irActInN` low, the block forwards from the bus. `rxEn` is 0, `irRxEn` is 1, `txEn` is all ones apart from jabbered or partitioned ports, and `irTxEn` is 0.
- R10: With cascade enabled, two or more foreign low lines, or a local carrier together with a foreign low line, put the block into jamming.
- R11: A change on `crsIn` or `irActInN` applied before clock edge 1 has no effect on the outputs after edge 2, and is fully reflected after edge 3.
- R12: Once every carrier is low and no foreign line is low, the block returns to the quiet state with every enable at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz local clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cascadeEn | input | 1 | 1 enables the multi-device activity bus |
| repId | input | 3 | Repeater ID used to pick activity lines |
| crsIn | input | 6 | Carrier sense per port (asynchronous) |
| rxDv | input | 1 | Receive data valid of the port being forwarded |
| jabber | input | 6 | Per-port jabber status |
| partition | input | 6 | Per-port partition status |
| irActInN | input | 8 | Activity bus as sensed (asynchronous, active low) |
| rxEn | output | 6 | Per-port receive enable |
| txEn | output | 6 | Per-port transmit enable |
| irRxEn | output | 1 | Take data from the cascade bus |
| irTxEn | output | 1 | Drive data onto the cascade bus |
| jamSel | output | 1 | Transmit the jam pattern instead of data |
| irActOutN | output | 8 | Activity lines to pull low (0 = drive low) |

## Verification
The bench reads the activity bus back as the wired-AND of the device's own lines and a remote device's lines. A design that did not mask its own lines would then jam itself a few cycles after it starts forwarding, or would see phantom bus traffic just after it releases a line. The bench times the data-valid stall to the exact cycle and checks that a stall-caused jam never turns into last-port jamming. A design with an off-by-one counter, or one that treated the stall like a multi-source collision, would fail these checks. The bench also targets the ID-0 partner line and the last port that survives a local-versus-remote collision, because a wrong line index or a lost port capture shows up only in those cases.

// File: rtl/rpt_core_pkg.sv
package rpt_core_pkg;

  typedef enum logic [2:0] {
    ST_QUIET      = 3'd0,
    ST_FWD_LOCAL  = 3'd1,
    ST_FWD_REMOTE = 3'd2,
    ST_JAM        = 3'd3,
    ST_LAST_PORT  = 3'd4
  } rptState_e;

  // observations handed from datapath to control
  typedef struct packed {
    logic localNone;
    logic localOne;
    logic localMany;
    logic remoteOne;
    logic remoteMany;
    logic dvStall;
  } obsFlags_t;

  // strobes handed from control to datapath
  typedef struct packed {
    rptState_e state;
    logic      capturePort;
  } ctrlStrobe_t;

endpackage

// File: rtl/rpt_sync.sv
module rpt_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic RESET_BIT = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= {WIDTH{RESET_BIT}};
    end else begin
      chain[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/rpt_core_datapath.sv
module rpt_core_datapath
  import rpt_core_pkg::*;
#(
  parameter int NUM_PORTS   = 6,
  parameter int IR_LINES    = 8,
  parameter int DV_LIMIT    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int ID_W   = $clog2(IR_LINES),
  localparam int PCNT_W = $clog2(NUM_PORTS + 1),
  localparam int RCNT_W = $clog2(IR_LINES + 1),
  localparam int DVC_W  = $clog2(DV_LIMIT + 2)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cascadeEn,
  input  logic [ID_W-1:0]      repId,
  input  logic [NUM_PORTS-1:0] crsIn,
  input  logic                 rxDv,
  input  logic [NUM_PORTS-1:0] jabber,
  input  logic [NUM_PORTS-1:0] partition,
  input  logic [IR_LINES-1:0]  irActInN,
  input  ctrlStrobe_t          ctrl,
  output obsFlags_t            obs,
  output logic [NUM_PORTS-1:0] rxEn,
  output logic [NUM_PORTS-1:0] txEn,
  output logic                 irRxEn,
  output logic                 irTxEn,
  output logic                 jamSel,
  output logic [IR_LINES-1:0]  irActOutN
);

  logic [NUM_PORTS-1:0] crsSync;
  logic [IR_LINES-1:0]  busSyncN;
  logic [PCNT_W-1:0]    localCnt;
  logic [RCNT_W-1:0]    remoteCnt;
  logic [IR_LINES-1:0]  ownHist [SYNC_STAGES];
  logic [IR_LINES-1:0]  ownMask;
  logic [IR_LINES-1:0]  foreignLow;
  logic [DVC_W-1:0]     dvCnt;
  logic [NUM_PORTS-1:0] portSel;
  logic [IR_LINES-1:0]  actOutQ;
  logic [IR_LINES-1:0]  actOutD;
  logic [ID_W-1:0]      partnerId;
  logic [NUM_PORTS-1:0] blocked;

  rpt_sync #(.WIDTH(NUM_PORTS), .STAGES(SYNC_STAGES), .RESET_BIT(1'b0)) u_crsSync (
    .clk(clk), .rstN(rstN), .asyncIn(crsIn), .syncOut(crsSync));

  rpt_sync #(.WIDTH(IR_LINES), .STAGES(SYNC_STAGES), .RESET_BIT(1'b1)) u_busSync (
    .clk(clk), .rstN(rstN), .asyncIn(irActInN), .syncOut(busSyncN));

  // population counts of the decoded activity
  always_comb begin
    localCnt = '0;
    for (int i = 0; i < NUM_PORTS; i++) localCnt = localCnt + PCNT_W'(crsSync[i]);
  end

  // lines this device drove recently are still in flight through the synchronizer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) ownHist[s] <= '0;
    end else begin
      ownHist[0] <= ~actOutQ;
      for (int s = 1; s < SYNC_STAGES; s++) ownHist[s] <= ownHist[s-1];
    end
  end

  always_comb begin
    ownMask = ~actOutQ;
    for (int s = 0; s < SYNC_STAGES; s++) ownMask = ownMask | ownHist[s];
    foreignLow = ~busSyncN & ~ownMask & {IR_LINES{cascadeEn}};
    remoteCnt = '0;
    for (int i = 0; i < IR_LINES; i++) remoteCnt = remoteCnt + RCNT_W'(foreignLow[i]);
  end

  // data-valid stall counter for a lone carrier
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dvCnt <= '0;
    end else if (localCnt == PCNT_W'(1) && !rxDv) begin
      if (dvCnt <= DVC_W'(DV_LIMIT)) dvCnt <= dvCnt + 1'b1;
    end else begin
      dvCnt <= '0;
    end
  end

  always_comb begin
    obs.localNone  = (localCnt == '0);
    obs.localOne   = (localCnt == PCNT_W'(1));
    obs.localMany  = (localCnt > PCNT_W'(1));
    obs.remoteOne  = (remoteCnt == RCNT_W'(1));
    obs.remoteMany = (remoteCnt > RCNT_W'(1));
    obs.dvStall    = (dvCnt > DVC_W'(DV_LIMIT));
  end

  // the active local port, captured on the control's strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 portSel <= '0;
    else if (ctrl.capturePort) portSel <= crsSync;
  end

  // activity bus encoding
  assign partnerId = (repId == '0) ? ID_W'(1) : repId - 1'b1;

  always_comb begin
    actOutD = '1;
    if (cascadeEn && localCnt != '0) begin
      actOutD[repId] = 1'b0;
      if (localCnt > PCNT_W'(1)) actOutD[partnerId] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) actOutQ <= '1;
    else       actOutQ <= actOutD;
  end

  assign irActOutN = actOutQ;

  // enable generation from the current state
  assign blocked = jabber | partition;

  always_comb begin
    rxEn   = '0;
    txEn   = '0;
    irRxEn = 1'b0;
    irTxEn = 1'b0;
    jamSel = 1'b0;
    unique case (ctrl.state)
      ST_FWD_LOCAL: begin
        rxEn   = portSel;
        txEn   = ~portSel & ~blocked;
        irTxEn = cascadeEn;
      end
      ST_FWD_REMOTE: begin
        irRxEn = 1'b1;
        txEn   = ~blocked;
      end
      ST_JAM: begin
        txEn   = '1;
        jamSel = 1'b1;
      end
      ST_LAST_PORT: begin
        txEn   = ~portSel;
        jamSel = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rpt_core_control.sv
module rpt_core_control
  import rpt_core_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  obsFlags_t   obs,
  output ctrlStrobe_t ctrl
);

  rptState_e stateQ, stateD;
  logic      multiQ, multiD;
  logic      captureD;
  logic      remoteAny, collide;

  assign remoteAny = obs.remoteOne | obs.remoteMany;
  assign collide   = obs.localMany | obs.remoteMany | (!obs.localNone && remoteAny);

  always_comb begin
    stateD   = stateQ;
    captureD = 1'b0;
    unique case (stateQ)
      ST_QUIET: begin
        if (collide) stateD = ST_JAM;
        else if (obs.localOne) begin
          stateD   = ST_FWD_LOCAL;
          captureD = 1'b1;
        end
        else if (obs.remoteOne) stateD = ST_FWD_REMOTE;
      end
      ST_FWD_LOCAL: begin
        if (collide || obs.dvStall) stateD = ST_JAM;
        else if (obs.localNone)     stateD = ST_QUIET;
      end
      ST_FWD_REMOTE: begin
        if (collide)         stateD = ST_JAM;
        else if (!remoteAny) stateD = ST_QUIET;
      end
      ST_JAM: begin
        if (collide) stateD = ST_JAM;
        else if (obs.localOne && !remoteAny && multiQ) begin
          stateD   = ST_LAST_PORT;
          captureD = 1'b1;
        end
        else if (obs.localNone && !remoteAny) stateD = ST_QUIET;
      end
      ST_LAST_PORT: begin
        if (collide)            stateD = ST_JAM;
        else if (obs.localNone) stateD = ST_QUIET;
      end
      default: stateD = ST_QUIET;
    endcase
  end

  // remembers whether the current jam involved more than one source
  assign multiD = (stateD == ST_QUIET) ? 1'b0 : (multiQ | collide);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_QUIET;
      multiQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      multiQ <= multiD;
    end
  end

  assign ctrl.state       = stateQ;
  assign ctrl.capturePort = captureD;

endmodule

// File: rtl/rpt_core_ctrl.sv
module rpt_core_ctrl
  import rpt_core_pkg::*;
#(
  parameter int NUM_PORTS   = 6,
  parameter int IR_LINES    = 8,
  parameter int DV_LIMIT    = 4,
  parameter int SYNC_STAGES = 2,
  localparam int ID_W = $clog2(IR_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cascadeEn,
  input  logic [ID_W-1:0]      repId,
  input  logic [NUM_PORTS-1:0] crsIn,
  input  logic                 rxDv,
  input  logic [NUM_PORTS-1:0] jabber,
  input  logic [NUM_PORTS-1:0] partition,
  input  logic [IR_LINES-1:0]  irActInN,
  output logic [NUM_PORTS-1:0] rxEn,
  output logic [NUM_PORTS-1:0] txEn,
  output logic                 irRxEn,
  output logic                 irTxEn,
  output logic                 jamSel,
  output logic [IR_LINES-1:0]  irActOutN
);

  obsFlags_t   obs;
  ctrlStrobe_t ctrl;

  rpt_core_datapath #(
    .NUM_PORTS(NUM_PORTS), .IR_LINES(IR_LINES),
    .DV_LIMIT(DV_LIMIT), .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .cascadeEn(cascadeEn), .repId(repId),
    .crsIn(crsIn), .rxDv(rxDv), .jabber(jabber), .partition(partition),
    .irActInN(irActInN), .ctrl(ctrl), .obs(obs),
    .rxEn(rxEn), .txEn(txEn), .irRxEn(irRxEn), .irTxEn(irTxEn),
    .jamSel(jamSel), .irActOutN(irActOutN));

  rpt_core_control u_control (
    .clk(clk), .rstN(rstN), .obs(obs), .ctrl(ctrl));

endmodule

// File: rtl/rpt_core_ctrl_chk.sv
module rpt_core_ctrl_chk #(
  parameter int NUM_PORTS = 6,
  parameter int IR_LINES  = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 cascadeEn,
  input logic [NUM_PORTS-1:0] rxEn,
  input logic [NUM_PORTS-1:0] txEn,
  input logic                 irRxEn,
  input logic                 irTxEn,
  input logic                 jamSel,
  input logic [IR_LINES-1:0]  irActOutN
);

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_quiet_chk: assert (rxEn == '0 && txEn == '0 && !irRxEn && !irTxEn
                               && !jamSel && irActOutN == '1);
    end
  end

  // R2
  rx_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rxEn));

  // R2
  no_echo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxEn & txEn) == '0);

  // R4
  jam_no_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    jamSel |-> (rxEn == '0 && !irRxEn && !irTxEn));

  // R9
  bus_rx_chk: assert property (@(posedge clk) disable iff (!rstN)
    irRxEn |-> (rxEn == '0 && !irTxEn && !jamSel));

  // R7
  act_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(~irActOutN) <= 2);

  // R7
  act_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cascadeEn && $past(!cascadeEn)) |-> irActOutN == '1);

endmodule

bind rpt_core_ctrl rpt_core_ctrl_chk #(.NUM_PORTS(NUM_PORTS), .IR_LINES(IR_LINES)) u_chk (
  .clk(clk), .rstN(rstN), .cascadeEn(cascadeEn), .rxEn(rxEn), .txEn(txEn),
  .irRxEn(irRxEn), .irTxEn(irTxEn), .jamSel(jamSel), .irActOutN(irActOutN));

// File: tb/tb_rpt_core_ctrl.sv
module tb_rpt_core_ctrl;

  localparam int M_QUIET = 0, M_FWDL = 1, M_FWDR = 2, M_JAM = 3, M_LAST = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic       cascadeEn = 1'b0;
  logic [2:0] repId = 3'd0;
  logic [5:0] crsIn = '0;
  logic       rxDv = 1'b1;
  logic [5:0] jabber = '0;
  logic [5:0] partition = '0;
  logic [7:0] remoteN = '1;
  logic [7:0] irActInN;
  logic [5:0] rxEn, txEn;
  logic       irRxEn, irTxEn, jamSel;
  logic [7:0] irActOutN;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  // wired-AND bus: this device plus one remote device
  assign irActInN = remoteN & irActOutN;

  rpt_core_ctrl dut (
    .clk(clk), .rstN(rstN), .cascadeEn(cascadeEn), .repId(repId),
    .crsIn(crsIn), .rxDv(rxDv), .jabber(jabber), .partition(partition),
    .irActInN(irActInN), .rxEn(rxEn), .txEn(txEn), .irRxEn(irRxEn),
    .irTxEn(irTxEn), .jamSel(jamSel), .irActOutN(irActOutN));

  function automatic logic [14:0] expCore(int mode, logic [5:0] act, logic [5:0] blk, logic casc);
    logic [5:0] rx, tx;
    logic ir, it, jm;
    rx = '0; tx = '0; ir = 0; it = 0; jm = 0;
    case (mode)
      M_FWDL: begin rx = act; tx = ~act & ~blk; it = casc; end
      M_FWDR: begin ir = 1'b1; tx = ~blk; end
      M_JAM:  begin tx = '1; jm = 1'b1; end
      M_LAST: begin tx = ~act; jm = 1'b1; end
      default: ;
    endcase
    return {rx, tx, ir, it, jm};
  endfunction

  function automatic logic [7:0] expAct(logic casc, logic [2:0] id, int cnt);
    logic [7:0] v;
    v = '1;
    if (casc && cnt > 0) begin
      v[id] = 1'b0;
      if (cnt > 1) v[(id == 3'd0) ? 3'd1 : id - 3'd1] = 1'b0;
    end
    return v;
  endfunction

  task automatic settle(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chkCore(string tag, int mode, logic [5:0] act);
    logic [14:0] e, a;
    e = expCore(mode, act, jabber | partition, cascadeEn);
    a = {rxEn, txEn, irRxEn, irTxEn, jamSel};
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: {rx,tx,irRx,irTx,jam} got %b expected %b", tag, a, e);
    end
  endtask

  task automatic chkAct(string tag, logic [7:0] e);
    checks++;
    if (irActOutN !== e) begin
      errors++;
      $display("FAIL %s: irActOutN got %b expected %b", tag, irActOutN, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #1 rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chkCore("R1 during reset", M_QUIET, '0);
    chkAct("R1 during reset", 8'hFF);
    rstN = 1'b1;
    settle(2);
    chkCore("R1 after reset", M_QUIET, '0);
    chkAct("R1 after reset", 8'hFF);

    // R11 latency then R2 forwarding
    crsIn = 6'b000100;
    settle(2);
    chkCore("R11 no change after edge 2", M_QUIET, '0);
    settle(1);
    chkCore("R2 single port forward", M_FWDL, 6'b000100);
    jabber = 6'b000001; partition = 6'b100000;
    settle(0);
    chkCore("R3 blocked ports excluded", M_FWDL, 6'b000100);
    jabber = '0; partition = '0;
    crsIn = '0;
    settle(3);
    chkCore("R12 back to quiet", M_QUIET, '0);

    // R4 / R5 local collision then one port left
    crsIn = 6'b010010;
    settle(3);
    chkCore("R4 two carriers jam", M_JAM, '0);
    crsIn = 6'b010000;
    settle(3);
    chkCore("R5 last port jamming", M_LAST, 6'b010000);
    crsIn = '0;
    settle(3);
    chkCore("R5 last port leaves", M_QUIET, '0);

    // R6 data-valid stall
    rxDv = 1'b0; crsIn = 6'b000001;
    settle(7);
    chkCore("R6 still forwarding at cycle 5", M_FWDL, 6'b000001);
    settle(1);
    chkCore("R6 stall jams", M_JAM, '0);
    settle(6);
    chkCore("R6 stall jam holds no last-port", M_JAM, '0);
    crsIn = '0; rxDv = 1'b1;
    settle(3);
    chkCore("R6 stall released", M_QUIET, '0);

    // cascade, local source
    cascadeEn = 1'b1; repId = 3'd3;
    crsIn = 6'b000100;
    settle(3);
    chkCore("R8 cascade local forward", M_FWDL, 6'b000100);
    chkAct("R7 one local active id3", 8'b1111_0111);
    settle(5);
    chkCore("R8 own line not remote", M_FWDL, 6'b000100);
    crsIn = 6'b001100;
    settle(3);
    chkCore("R4 cascade local collision", M_JAM, '0);
    chkAct("R7 two local active id3", 8'b1111_0011);
    crsIn = '0;
    settle(3);
    chkAct("R7 idle lines high", 8'hFF);
    settle(3);
    chkCore("R12 quiet after own lines release", M_QUIET, '0);
    repId = 3'd0;
    crsIn = 6'b100001;
    settle(3);
    chkAct("R7 id0 partner line 1", 8'b1111_1100);
    crsIn = '0;
    settle(6);

    // cascade, remote source
    repId = 3'd3;
    remoteN = ~8'h20;
    settle(3);
    chkCore("R9 forward from bus", M_FWDR, '0);
    partition = 6'b000010;
    settle(0);
    chkCore("R3 bus forward blocked port", M_FWDR, '0);
    partition = '0;
    crsIn = 6'b000001;
    settle(3);
    chkCore("R10 local plus remote jam", M_JAM, '0);
    chkAct("R7 local one during remote", 8'b1111_0111);
    remoteN = '1;
    settle(3);
    chkCore("R5 survivor after remote leaves", M_LAST, 6'b000001);
    crsIn = '0;
    settle(6);
    chkCore("R12 quiet after cascade", M_QUIET, '0);
    remoteN = ~8'h60;
    settle(3);
    chkCore("R10 two remote lines jam", M_JAM, '0);
    remoteN = '1;
    settle(3);
    chkCore("R12 remote release quiet", M_QUIET, '0);

    // cascade disabled
    cascadeEn = 1'b0;
    crsIn = 6'b000011;
    settle(3);
    chkAct("R7 cascade off lines high", 8'hFF);
    chkCore("R4 jam cascade off", M_JAM, '0);
    crsIn = '0;
    settle(3);

    // constrained random
    for (int it = 0; it < 60; it++) begin
      logic [5:0] p;
      int kind, cnt;
      kind = int'($urandom % 3);
      if (kind == 0) p = 6'b1 << ($urandom % 6);
      else if (kind == 1) begin
        p = 6'($urandom % 64);
        while ($countones(p) < 2) p = 6'($urandom % 64);
      end else p = '0;
      cnt = $countones(p);
      cascadeEn = 1'($urandom % 2);
      repId = 3'($urandom % 8);
      jabber = 6'($urandom % 64);
      partition = 6'($urandom % 64) & 6'($urandom % 64);
      crsIn = p;
      settle(3);
      if (cnt == 1) chkCore("R2 random single", M_FWDL, p);
      else if (cnt > 1) chkCore("R4 random multi", M_JAM, '0);
      else chkCore("R12 random none", M_QUIET, '0);
      chkAct("R7 random lines", expAct(cascadeEn, repId, cnt));
      crsIn = '0;
      settle(3);
      chkCore("R12 random release", M_QUIET, '0);
      settle(3);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule